// File: doc/BRIEF.md
# Processor Timer Mode Hub

This block groups one system timer and a parameterised set of per-processor timers, up to sixteen, behind a single word-addressed register space. A shared address is decoded into a 20-byte window for the system timer and a 16-byte window for each processor timer. Reads are combinational. Writes and read side effects land on the rising clock edge.

A mode register lives in the system window. Each of its bits moves one processor timer between two kinds of operation. In limit mode the timer raises an interrupt each time its count reaches the programmed limit. In user mode it runs as a free counter that never interrupts. Writing the mode register applies the per-timer actions in the same clock edge: force the interrupt low, set the limit to maximum, stop, or restart.

Each timer counts up by one per clock while running. It wraps to zero when it reaches its limit, and a limit of zero means wrap at the all-ones count. The system interrupt drives a shared output, and each processor interrupt drives its own output bit.

Top module: `multi_timer_hub`

## Requirements
- R1: Processor timer i answers at byte offsets 0x1000*i to 0x1000*i+0xF, and the system timer answers at 0x10000 to 0x10013. A read at any other address returns 0, and a write there changes nothing. Offset 0x10 of a processor window lies outside that window.
- R2: The mode register is at system offset 0x10. Bit i selects user mode for processor timer i. Only the low NUM_CPU bits of a write are kept. It reads back as 0 after reset.
- R3: Writing 1 to a mode bit forces that processor's interrupt low and sets its limit to all ones, both at the write's clock edge.
- R4: Writing 0 to a mode bit that was already 0 stops that processor timer.
- R5: Writing a mode bit with a value different from its stored value clears that timer's count to 0 and leaves the timer running.
- R6: A running limit-mode timer with limit L>0 raises its interrupt L clock edges after its count was cleared. The count then restarts from 0. A limit of 0 wraps at the all-ones count. A user-mode timer never raises its interrupt.
- R7: Offset 0x0 reads the limit. In limit mode that read also clears the interrupt. In user mode it leaves the interrupt unchanged.
- R8: Offset 0xC reads the running flag in bit 0. A write there sets the running flag from bit 0 only for a processor timer in user mode, and is otherwise ignored. Every timer runs after reset.
- R9: Offset 0x4 reads the count in the low bits and, in limit mode, the interrupt flag in bit 31. A write there in user mode clears the count; in limit mode it is ignored.
- R10: A write at offset 0x8 loads the limit and leaves the count unchanged.
- R11: A write at offset 0x0 clears the count and the interrupt. In limit mode it loads the limit; in user mode it sets the limit to all ones.
- R12: The system timer's interrupt drives `sys_irq`, and processor timer i's interrupt drives `cpu_irq[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 17 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| sys_irq | output | 1 | System timer interrupt |
| cpu_irq | output | NUM_CPU | Per-processor timer interrupts |

## Verification
The bench builds the hub with NUM_CPU=3 and CNT_W=8. Three processors make the mode mask non-trivial, so a written value of 0xF must read back as 0x7. They also leave the fourth processor window unmapped, which lets the bench probe it. The 8-bit counter keeps the all-ones limit at 0xFF, so limit values can be checked exactly, and short limits of 3 and 5 let the bench count interrupt timing edge by edge.

// File: rtl/tmrhub_pkg.sv
package tmrhub_pkg;

    localparam int ADDR_W     = 17;
    localparam int DATA_W     = 32;
    localparam int SYS_BASE   = 'h10000;
    localparam int SYS_SPAN   = 'h14;
    localparam int CPU_STRIDE = 'h1000;
    localparam int CPU_SPAN   = 'h10;
    localparam int MAX_CPU    = 16;

    typedef enum logic [2:0] {
        REG_LIMIT      = 3'd0,
        REG_COUNT      = 3'd1,
        REG_LIMIT_KEEP = 3'd2,
        REG_RUN        = 3'd3,
        REG_MODE       = 3'd4,
        REG_RSV5       = 3'd5,
        REG_RSV6       = 3'd6,
        REG_RSV7       = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_idx_e          idx;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic force_max;
        logic halt;
        logic restart;
    } mode_act_t;

    function automatic reg_idx_e word_index(input logic [ADDR_W-1:0] a);
        return reg_idx_e'(a[4:2]);
    endfunction

endpackage

// File: rtl/tmrhub_decode.sv
module tmrhub_decode
    import tmrhub_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               sys_sel,
    output logic [NUM_CPU-1:0] cpu_sel,
    output reg_idx_e           idx
);
    localparam int HI_W = ADDR_W - 12;
    localparam logic [ADDR_W-1:0] SYS_LO = ADDR_W'(SYS_BASE);
    localparam logic [ADDR_W-1:0] SYS_HI = ADDR_W'(SYS_BASE + SYS_SPAN);
    localparam logic [11:0] CPU_TOP = 12'(CPU_SPAN);

    assign idx     = word_index(addr);
    assign sys_sel = (addr >= SYS_LO) && (addr < SYS_HI);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu_win
        assign cpu_sel[i] = (addr[ADDR_W-1:12] == HI_W'(i)) && (addr[11:0] < CPU_TOP);
    end

    always_comb begin
        assert_one_window_R1: assert ($onehot0({sys_sel, cpu_sel}))
            else $error("address hits more than one window");
    end

endmodule

// File: rtl/tmrhub_mode.sv
module tmrhub_mode
    import tmrhub_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [NUM_CPU-1:0]          wdata,
    output logic [NUM_CPU-1:0]          mode_q,
    output mode_act_t [NUM_CPU-1:0]     act
);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else if (wr) mode_q <= wdata;
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_act
        assign act[i].force_max = wr &  wdata[i];
        assign act[i].halt      = wr & ~wdata[i];
        assign act[i].restart   = wr & (wdata[i] ^ mode_q[i]);
    end

    assert_mode_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> mode_q == $past(wdata));

endmodule

// File: rtl/tmrhub_timer.sv
module tmrhub_timer
    import tmrhub_pkg::*;
#(
    parameter int CNT_W  = 31,
    parameter bit IS_CPU = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              sel,
    input  logic              user_mode,
    input  mode_act_t         act,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q, lim_q, wrap_at;
    logic             reached_q, run_q;
    logic             bus_wr, bus_rd;

    assign bus_wr  = sel & req.wr;
    assign bus_rd  = sel & req.rd;
    assign wrap_at = (lim_q == '0) ? ALL_ONES : lim_q - 1'b1;
    assign irq     = reached_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            run_q     <= 1'b1;
        end else begin
            if (run_q) begin
                if (cnt_q == wrap_at) begin
                    cnt_q <= '0;
                    if (!user_mode) reached_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (bus_wr) begin
                case (req.idx)
                    REG_LIMIT: begin
                        cnt_q     <= '0;
                        reached_q <= 1'b0;
                        lim_q     <= user_mode ? ALL_ONES : req.wdata[CNT_W-1:0];
                    end
                    REG_COUNT: if (user_mode) begin
                        cnt_q     <= '0;
                        reached_q <= 1'b0;
                    end
                    REG_LIMIT_KEEP: lim_q <= req.wdata[CNT_W-1:0];
                    REG_RUN: if (IS_CPU && user_mode) run_q <= req.wdata[0];
                    default: ;
                endcase
            end
            if (bus_rd && req.idx == REG_LIMIT && !user_mode) reached_q <= 1'b0;
            if (act.force_max) begin
                lim_q     <= ALL_ONES;
                reached_q <= 1'b0;
            end
            if (act.halt) run_q <= 1'b0;
            if (act.restart) begin
                cnt_q <= '0;
                run_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (req.idx)
            REG_LIMIT, REG_LIMIT_KEEP: rdata = DATA_W'(lim_q);
            REG_COUNT: rdata = {reached_q & ~user_mode, 31'(cnt_q)};
            REG_RUN:   rdata = DATA_W'(run_q);
            default:   rdata = '0;
        endcase
    end

    assert_force_low_R3: assert property (@(posedge clk) disable iff (rst)
        act.force_max |=> (!irq && lim_q == ALL_ONES));

    assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (act.halt && !act.restart) |=> !run_q);

    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        act.restart |=> (run_q && cnt_q == '0));

    assert_user_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(user_mode));

endmodule

// File: rtl/multi_timer_hub.sv
module multi_timer_hub
    import tmrhub_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CNT_W   = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [16:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               sys_irq,
    output logic [NUM_CPU-1:0] cpu_irq
);
    initial begin
        if (NUM_CPU < 1 || NUM_CPU > MAX_CPU || CNT_W < 2 || CNT_W > 31)
            $error("multi_timer_hub: parameter out of range");
    end

    logic               sys_sel;
    logic [NUM_CPU-1:0] cpu_sel;
    reg_idx_e           idx;
    reg_req_t           req;
    logic [NUM_CPU-1:0] mode_q;
    mode_act_t [NUM_CPU-1:0] act;
    logic [DATA_W-1:0]  sys_rd;
    logic [DATA_W-1:0]  cpu_rd [NUM_CPU];
    logic               mode_wr;

    tmrhub_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .addr    (bus_addr),
        .sys_sel (sys_sel),
        .cpu_sel (cpu_sel),
        .idx     (idx)
    );

    assign req = '{wr: bus_wr, rd: bus_rd, idx: idx, wdata: bus_wdata};
    assign mode_wr = bus_wr && sys_sel && idx == REG_MODE;

    tmrhub_mode #(.NUM_CPU(NUM_CPU)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (mode_wr),
        .wdata  (bus_wdata[NUM_CPU-1:0]),
        .mode_q (mode_q),
        .act    (act)
    );

    tmrhub_timer #(.CNT_W(CNT_W), .IS_CPU(1'b0)) u_sys_timer (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sel       (sys_sel),
        .user_mode (1'b0),
        .act       (mode_act_t'('0)),
        .rdata     (sys_rd),
        .irq       (sys_irq)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        tmrhub_timer #(.CNT_W(CNT_W), .IS_CPU(1'b1)) u_cpu_timer (
            .clk       (clk),
            .rst       (rst),
            .req       (req),
            .sel       (cpu_sel[i]),
            .user_mode (mode_q[i]),
            .act       (act[i]),
            .rdata     (cpu_rd[i]),
            .irq       (cpu_irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (sys_sel) bus_rdata = (idx == REG_MODE) ? DATA_W'(mode_q) : sys_rd;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu_sel[i]) bus_rdata = cpu_rd[i];
        end
    end

endmodule

// File: tb/multi_timer_hub_bench.sv
`timescale 1ns/1ps
module multi_timer_hub_bench;

    localparam int N = 3;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_irq;
    logic [N-1:0] cpu_irq;

    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    multi_timer_hub #(.NUM_CPU(N), .CNT_W(W)) u_multi_timer_hub (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_irq(sys_irq), .cpu_irq(cpu_irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [16:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 17'h10010, 32'h0,  8'd2},  // R2 reset mode 0
        '{1'b1, 17'h00000, 32'h0,  8'd11}, // R11 reset limit 0
        '{1'b1, 17'h0000C, 32'h1,  8'd8},  // R8 runs after reset
        '{1'b0, 17'h10010, 32'h0,  8'd4},  // R4 stop all
        '{1'b1, 17'h0000C, 32'h0,  8'd4},  // R4
        '{1'b1, 17'h0100C, 32'h0,  8'd4},  // R4
        '{1'b0, 17'h00000, 32'h20, 8'd11}, // R11 limit write
        '{1'b1, 17'h00004, 32'h0,  8'd11}, // R11 count cleared
        '{1'b1, 17'h00000, 32'h20, 8'd11}, // R11
        '{1'b0, 17'h00008, 32'h33, 8'd10}, // R10 limit keep
        '{1'b1, 17'h00000, 32'h33, 8'd10}, // R10
        '{1'b0, 17'h0000C, 32'h1,  8'd8},  // R8 ignored in limit mode
        '{1'b1, 17'h0000C, 32'h0,  8'd8},  // R8
        '{1'b0, 17'h10010, 32'hF,  8'd2},  // R2 masked, R5 restart
        '{1'b1, 17'h10010, 32'h7,  8'd2},  // R2
        '{1'b1, 17'h00000, 32'hFF, 8'd3},  // R3 limit max
        '{1'b1, 17'h0200C, 32'h1,  8'd5},  // R5 running
        '{1'b0, 17'h0000C, 32'h0,  8'd8},  // R8 user stop
        '{1'b1, 17'h0000C, 32'h0,  8'd8},  // R8
        '{1'b0, 17'h00004, 32'h9,  8'd9},  // R9 user count clear
        '{1'b1, 17'h00004, 32'h0,  8'd9},  // R9
        '{1'b0, 17'h00000, 32'h12, 8'd11}, // R11 user limit write
        '{1'b1, 17'h00000, 32'hFF, 8'd11}, // R11
        '{1'b0, 17'h10010, 32'h6,  8'd5},  // R5 cpu0 changes
        '{1'b1, 17'h0000C, 32'h1,  8'd5},  // R5
        '{1'b1, 17'h00000, 32'hFF, 8'd5},  // R5 limit kept
        '{1'b0, 17'h01010, 32'h1,  8'd1},  // R1 outside cpu1 window
        '{1'b1, 17'h10010, 32'h6,  8'd1},  // R1
        '{1'b1, 17'h00010, 32'h0,  8'd1},  // R1
        '{1'b1, 17'h03000, 32'h0,  8'd1},  // R1 absent cpu3
        '{1'b1, 17'h10014, 32'h0,  8'd1},  // R1
        '{1'b0, 17'h10010, 32'h0,  8'd4},  // R4 cpu0 stop, R5 cpu1/2
        '{1'b1, 17'h0000C, 32'h0,  8'd4},  // R4
        '{1'b1, 17'h0200C, 32'h1,  8'd5},  // R5
        '{1'b1, 17'h0100C, 32'h1,  8'd5}   // R5
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start just after a falling edge and end at the next one.
    task automatic bus_write(input logic [16:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [16:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata, exp, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({31'b0, sys_irq}, 32'h0, "R12 reset sys_irq");
        chk(32'(cpu_irq), 32'h0, "R12 reset cpu_irq");

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_rd)
                bus_read(VECS[k].addr, VECS[k].data, $sformatf("R%0d vec%0d", VECS[k].req, k));
            else
                bus_write(VECS[k].addr, VECS[k].data);
        end

        // R6: cpu1 limit mode, limit 5 -> irq after 5 edges
        bus_write(17'h01000, 32'h5);
        repeat (4) @(negedge clk);
        chk(32'(cpu_irq[1]), 32'h0, "R6 irq early");
        @(negedge clk);
        chk(32'(cpu_irq[1]), 32'h1, "R6 irq at limit");
        chk(32'(cpu_irq[0]), 32'h0, "R12 cpu0 quiet");
        bus_read(17'h01004, 32'h8000_0000, "R9 reached flag");
        bus_read(17'h01000, 32'h5, "R7 limit read");
        chk(32'(cpu_irq[1]), 32'h0, "R7 irq cleared");

        // R3: mode write while irq pending
        for (int t = 0; t < 20 && !cpu_irq[1]; t++) @(negedge clk);
        chk(32'(cpu_irq[1]), 32'h1, "R6 irq again");
        bus_write(17'h10010, 32'h2);
        chk(32'(cpu_irq[1]), 32'h0, "R3 forced low");
        bus_read(17'h01000, 32'hFF, "R3 limit max");
        repeat (300) @(negedge clk);
        chk(32'(cpu_irq[1]), 32'h0, "R6 user never irq");

        // R12: system timer, limit 3
        bus_write(17'h10000, 32'h3);
        repeat (2) @(negedge clk);
        chk({31'b0, sys_irq}, 32'h0, "R12 sys early");
        @(negedge clk);
        chk({31'b0, sys_irq}, 32'h1, "R12 sys irq");
        chk(32'(cpu_irq[0]), 32'h0, "R12 cpu0 separate");
        bus_read(17'h10000, 32'h3, "R7 sys limit");
        chk({31'b0, sys_irq}, 32'h0, "R7 sys cleared");
        bus_write(17'h1000C, 32'h0);
        bus_read(17'h1000C, 32'h1, "R8 sys run write ignored");

        // reset in the middle of a run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_read(17'h10010, 32'h0, "R2 mode after reset");
        bus_read(17'h0000C, 32'h1, "R8 run after reset");

        finish_run();
    end

endmodule